// File: doc/BRIEF.md
# Duplicating Command Register with Parity Check

This block is the registered stage on a memory module's address and command path. On each rising clock edge it captures a 28-bit input word. The word holds 22 data bits, two select bits, two clock-enable bits and two termination-control bits. Every captured bit leaves the block twice, on an A copy and a B copy, so that each copy can drive half of the loads.

To save power, the 22 data outputs can be frozen while no select bit is active. A gating-enable input turns this freezing on or off. The select, clock-enable and termination outputs are never frozen.

An odd-parity checker covers the 22 data bits. The controller sends the parity bit one clock after the data it covers. A registered, active-low error flag reports a mismatch. The check runs only on words that carried at least one active select. A word of all zeros therefore never raises the flag, which matters during the quiet period after reset.

Top module: `cmdbuf_top`

## Requirements
- R1: With `gate_en` high and at least one bit of `d_cs` high at a rising edge, `q_data_a` and `q_data_b` both equal the `d_data` value sampled at that edge, one cycle later.
- R2: `q_cs_*`, `q_cke_*` and `q_odt_*` (A and B) equal the values of `d_cs`, `d_cke` and `d_odt` sampled at the previous rising edge, whatever the values of `gate_en` and `d_cs`.
- R3: With `gate_en` high and `d_cs` equal to 2'b00 at a rising edge, `q_data_a` and `q_data_b` keep their previous value.
- R4: With `gate_en` low, `q_data_a` and `q_data_b` take the sampled `d_data` at every edge, even when `d_cs` is 2'b00.
- R5: A select bit of 1 means active. If `d_data` is sampled at edge m with `d_cs` nonzero, `par_in` is sampled at edge m+1. If the XOR of the 22 data bits and `par_in` is 0, `err_n` is 0 after edge m+2; if it is 1, `err_n` is 1.
- R6: If `d_cs` was 2'b00 at edge m, `err_n` is 1 after edge m+2, whatever the data and parity values.
- R7: While `d_data`, `par_in` and `d_cs` are held all zero, `err_n` stays 1.
- R8: While the synchronous active-high `rst` is high, every registered output reads 0 and `err_n` reads 1. The parity pipeline is cleared, so `err_n` stays 1 for the first two edges after reset ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| gate_en | input | 1 | 1: an idle select freezes the data outputs |
| d_data | input | 22 | Data bits covered by parity |
| d_cs | input | 2 | Select bits, 1 = active |
| d_cke | input | 2 | Clock-enable bits |
| d_odt | input | 2 | Termination-control bits |
| par_in | input | 1 | Odd-parity bit, one clock after its data |
| q_data_a | output | 22 | Registered data, copy A |
| q_data_b | output | 22 | Registered data, copy B |
| q_cs_a | output | 2 | Registered selects, copy A |
| q_cs_b | output | 2 | Registered selects, copy B |
| q_cke_a | output | 2 | Registered clock enables, copy A |
| q_cke_b | output | 2 | Registered clock enables, copy B |
| q_odt_a | output | 2 | Registered termination controls, copy A |
| q_odt_b | output | 2 | Registered termination controls, copy B |
| err_n | output | 1 | Parity error flag, active low |

## Verification
The bench looks hardest at the alignment of parity with its data. A checker that paired the parity bit with the wrong data word would misflag the walking-one pattern and the pseudo-random traffic, where the parity bit alternates between matching and mismatching.

Every gate/select combination is swept. A design that froze the control outputs, or froze the data while gating was off, shows a stale value within one cycle.

The all-zero idle window and the cycles right after reset catch two further faults. A checker without the select qualifier would pull the flag low on an idle bus. A pipeline that is not cleared at reset would flag stale data.

// File: rtl/cmdbuf_pkg.sv
package cmdbuf_pkg;

    localparam int CB_DATA_W = 22;
    localparam int CB_SEL_W  = 2;
    localparam int CB_CTL_GROUPS = 3;

    // One slot of the parity pipeline
    typedef struct packed {
        logic act;   // word carried an active select
        logic sum;   // running XOR for that word
    } cb_par_stage_t;

    // Odd parity: the flag is active low, so it is high when the total XOR is 1
    function automatic logic cb_flag_level(input logic total_xor);
        return total_xor;
    endfunction

    function automatic logic cb_any_sel(input logic [CB_SEL_W-1:0] sel);
        return |sel;
    endfunction

endpackage

// File: rtl/cmdbuf_ctl_reg.sv
module cmdbuf_ctl_reg #(
    parameter int W = 2,
    parameter int GROUPS = 3
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [GROUPS-1:0][W-1:0] d,
    output logic [GROUPS-1:0][W-1:0] q
);

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        always_ff @(posedge clk) begin
            if (rst) q[g] <= '0;
            else     q[g] <= d[g];
        end
    end

    // R2: control groups follow their inputs every cycle, never gated
    a_r2_ctl_follow: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> q == $past(d));

endmodule

// File: rtl/cmdbuf_data_reg.sv
module cmdbuf_data_reg #(
    parameter int W = 22
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         gate_en,
    input  logic         sel_any,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic load;
    assign load = !gate_en || sel_any;

    always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (load) q <= d;
    end

    // R1 / R4: loads on a selected word or whenever gating is off
    a_r1_data_load: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && (!$past(gate_en) || $past(sel_any))) |-> q == $past(d));

    // R3: frozen while gated and unselected
    a_r3_data_hold: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(gate_en) && !$past(sel_any)) |-> $stable(q));

endmodule

// File: rtl/cmdbuf_parity.sv
module cmdbuf_parity
    import cmdbuf_pkg::*;
#(
    parameter int W = 22,
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [W-1:0]     d,
    input  logic [SEL_W-1:0] sel,
    input  logic             par_in,
    output logic             err_n
);

    cb_par_stage_t st_data;   // word captured
    cb_par_stage_t st_par;    // parity bit folded in

    always_ff @(posedge clk) begin
        if (rst) begin
            st_data <= '0;
            st_par  <= '0;
            err_n   <= 1'b1;
        end else begin
            st_data.act <= |sel;
            st_data.sum <= ^d;
            st_par.act  <= st_data.act;
            st_par.sum  <= st_data.sum ^ par_in;
            err_n       <= st_par.act ? cb_flag_level(st_par.sum) : 1'b1;
        end
    end

    // R6: no select two edges back keeps the flag high
    a_r6_idle_clear: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2) && !$past(rst, 3) && ($past(sel, 3) == '0))
        |-> err_n);

    // R5: selected word with even total parity pulls the flag low
    a_r5_flag_low: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2) && !$past(rst, 3) && ($past(sel, 3) != '0)
         && (((^$past(d, 3)) ^ $past(par_in, 2)) == 1'b0))
        |-> !err_n);

endmodule

// File: rtl/cmdbuf_top.sv
module cmdbuf_top
    import cmdbuf_pkg::*;
#(
    parameter int DATA_W = CB_DATA_W,
    parameter int SEL_W  = CB_SEL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              gate_en,
    input  logic [DATA_W-1:0] d_data,
    input  logic [SEL_W-1:0]  d_cs,
    input  logic [SEL_W-1:0]  d_cke,
    input  logic [SEL_W-1:0]  d_odt,
    input  logic              par_in,
    output logic [DATA_W-1:0] q_data_a,
    output logic [DATA_W-1:0] q_data_b,
    output logic [SEL_W-1:0]  q_cs_a,
    output logic [SEL_W-1:0]  q_cs_b,
    output logic [SEL_W-1:0]  q_cke_a,
    output logic [SEL_W-1:0]  q_cke_b,
    output logic [SEL_W-1:0]  q_odt_a,
    output logic [SEL_W-1:0]  q_odt_b,
    output logic              err_n
);

    localparam int GROUPS = CB_CTL_GROUPS;

    logic [GROUPS-1:0][SEL_W-1:0] ctl_d, ctl_q;
    logic [DATA_W-1:0]            data_q;
    logic                         sel_any;

    assign sel_any  = cb_any_sel(d_cs);
    assign ctl_d[0] = d_cs;
    assign ctl_d[1] = d_cke;
    assign ctl_d[2] = d_odt;

    cmdbuf_ctl_reg #(.W(SEL_W), .GROUPS(GROUPS)) u_ctl (
        .clk (clk),
        .rst (rst),
        .d   (ctl_d),
        .q   (ctl_q)
    );

    cmdbuf_data_reg #(.W(DATA_W)) u_data (
        .clk     (clk),
        .rst     (rst),
        .gate_en (gate_en),
        .sel_any (sel_any),
        .d       (d_data),
        .q       (data_q)
    );

    cmdbuf_parity #(.W(DATA_W), .SEL_W(SEL_W)) u_par (
        .clk    (clk),
        .rst    (rst),
        .d      (d_data),
        .sel    (d_cs),
        .par_in (par_in),
        .err_n  (err_n)
    );

    // Fan each register out to both copies
    assign q_data_a = data_q;
    assign q_data_b = data_q;
    assign q_cs_a   = ctl_q[0];
    assign q_cs_b   = ctl_q[0];
    assign q_cke_a  = ctl_q[1];
    assign q_cke_b  = ctl_q[1];
    assign q_odt_a  = ctl_q[2];
    assign q_odt_b  = ctl_q[2];

    // R8: the first edge after reset shows cleared outputs and a high flag
    a_r8_reset_clear: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (err_n && q_data_a == '0 && q_cs_a == '0
                        && q_cke_b == '0 && q_odt_b == '0));

endmodule

// File: tb/cmdbuf_top_bench.sv
module cmdbuf_top_bench;

    localparam int DW = 22;
    localparam int SW = 2;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst = 1'b1, gate_en = 1'b0, par_in = 1'b0;
    logic [DW-1:0] d_data = '0;
    logic [SW-1:0] d_cs = '0, d_cke = '0, d_odt = '0;
    logic [DW-1:0] q_data_a, q_data_b;
    logic [SW-1:0] q_cs_a, q_cs_b, q_cke_a, q_cke_b, q_odt_a, q_odt_b;
    logic          err_n;

    cmdbuf_top u_cmdbuf_top (
        .clk(clk), .rst(rst), .gate_en(gate_en), .d_data(d_data),
        .d_cs(d_cs), .d_cke(d_cke), .d_odt(d_odt), .par_in(par_in),
        .q_data_a(q_data_a), .q_data_b(q_data_b),
        .q_cs_a(q_cs_a), .q_cs_b(q_cs_b), .q_cke_a(q_cke_a), .q_cke_b(q_cke_b),
        .q_odt_a(q_odt_a), .q_odt_b(q_odt_b), .err_n(err_n)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    // Model state: the input set on the pins, and older sets
    logic          c_rst = 1'b1, c_gate = 1'b0, c_par = 1'b0;
    logic [DW-1:0] c_d = '0;
    logic [SW-1:0] c_cs = '0, c_cke = '0, c_odt = '0;
    logic [DW-1:0] h1_d = '0, h2_d = '0, h3_d = '0;
    logic [SW-1:0] h1_cs = '0, h2_cs = '0, h3_cs = '0;
    logic          h1_p = 1'b0, h2_p = 1'b0, h3_p = 1'b0;
    logic [DW-1:0] exp_d = '0;
    int            nvalid = 0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] xs(input logic [31:0] s);
        logic [31:0] v;
        v = s ^ (s << 13);
        v = v ^ (v >> 17);
        v = v ^ (v << 5);
        return v;
    endfunction

    task automatic step(input logic r, input logic g, input logic p,
                        input logic [DW-1:0] d, input logic [SW-1:0] cs,
                        input logic [SW-1:0] cke, input logic [SW-1:0] odt);
        string dreq, creq, ereq;
        logic  act, eexp;
        @(negedge clk);
        // the edge just passed sampled the c_* set
        if (c_rst) begin
            exp_d  = '0;
            nvalid = 0;
        end else begin
            if (!(c_gate && c_cs == '0)) exp_d = c_d;
            nvalid++;
        end
        h3_d = h2_d; h3_cs = h2_cs; h3_p = h2_p;
        h2_d = h1_d; h2_cs = h1_cs; h2_p = h1_p;
        h1_d = c_d;  h1_cs = c_cs;  h1_p = c_par;
        // data word from h3, parity bit from h2
        act  = (nvalid >= 3) && (h3_cs != '0);
        eexp = act ? ((^h3_d) ^ h2_p) : 1'b1;

        dreq = c_rst ? "R8" : (c_gate && c_cs == '0) ? "R3" : !c_gate ? "R4" : "R1";
        creq = c_rst ? "R8" : "R2";
        ereq = c_rst ? "R8" : act ? "R5" :
               (h3_d == '0 && h2_p == 1'b0 && h3_cs == '0) ? "R7" : "R6";

        check(dreq, 32'(q_data_a), 32'(exp_d));
        check(dreq, 32'(q_data_b), 32'(exp_d));
        check(creq, {q_cs_a, q_cs_b, q_cke_a, q_cke_b, q_odt_a, q_odt_b},
              c_rst ? 32'h0 : {c_cs, c_cs, c_cke, c_cke, c_odt, c_odt});
        check(ereq, 32'(err_n), 32'(eexp));

        c_rst = r; c_gate = g; c_par = p; c_d = d; c_cs = cs; c_cke = cke; c_odt = odt;
        rst = r; gate_en = g; par_in = p; d_data = d; d_cs = cs; d_cke = cke; d_odt = odt;
    endtask

    initial begin
        logic [31:0] s;
        s = 32'h1bad_5eed;
        // R8: reset with busy inputs
        for (int i = 0; i < 4; i++) begin
            s = xs(s);
            step(1'b1, s[31], s[30], s[DW-1:0], 2'b11, s[25:24], s[27:26]);
        end
        // R7: quiet all-zero window after reset
        for (int i = 0; i < 10; i++) step(1'b0, 1'b1, 1'b0, '0, 2'b00, 2'b11, 2'b00);
        // R5: walking one, parity alternating between match and mismatch
        for (int i = 0; i < DW; i++)
            step(1'b0, 1'b1, i[0], DW'(1) << i, 2'b01, 2'b11, 2'b01);
        // R1-style sweep of all gate/select combinations
        for (int k = 0; k < 16; k++) begin
            for (int i = 0; i < 8; i++) begin
                s = xs(s);
                step(1'b0, k[2], s[22], s[DW-1:0], k[1:0], s[25:24], s[27:26]);
            end
        end
        // pseudo-random traffic, gating off then on
        for (int i = 0; i < 300; i++) begin
            s = xs(s);
            step(1'b0, i >= 150, s[22], s[DW-1:0], s[29:28], s[25:24], s[27:26]);
        end
        // reset in mid-stream, then more traffic
        for (int i = 0; i < 2; i++) begin
            s = xs(s);
            step(1'b1, 1'b1, s[22], s[DW-1:0], 2'b10, s[25:24], s[27:26]);
        end
        for (int i = 0; i < 200; i++) begin
            s = xs(s);
            step(1'b0, s[30], s[22], s[DW-1:0], s[29:28], s[25:24], s[27:26]);
        end
        step(1'b0, 1'b0, 1'b0, '0, 2'b00, 2'b00, 2'b00);
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule